// File: doc/BRIEF.md
# Write-Enable and Block Protection Unit

This unit is the write-gating logic of a small serial memory. It keeps three pieces of state: a write-enable latch, a busy flag that marks a program cycle in progress, and a two-bit protection level that is retained across commands. A command decoder sends it single-cycle strobes for enable, disable, memory write and status write. A programming engine sends it a done pulse when a program cycle ends. From this it drives a write-permit signal for the addressed byte, the byte returned by a status read, and the current protection bits.

The protection level selects an upper part of the address space that cannot be written: none, the top quarter, the top half, or the whole array. A write must pass three tests before it starts a program cycle: the write-protect pin must be high, the enable latch must be set, and the target must lie outside the protected part. A write that passes sets the busy flag. When the done pulse arrives, the busy flag clears and so does the enable latch, so every further write needs a fresh enable. While busy, a status read returns all ones.

Top module: `prot_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, the enable latch, busy flag and protection bits are all 0, so status_o reads 8'h00 and wr_permit_o is 0.
- R2: When idle, en_set_i sets the enable latch (status bit 1) at the next clock edge and en_clr_i clears it. If both are asserted in the same cycle, the latch clears.
- R3: When idle, status_o is {4'b0000, bp[1], bp[0], wel, 1'b0}: bit 0 is busy, bit 1 is the enable latch, bits 3:2 are the protection level, and bits 7:4 are 0.
- R4: The protection level decodes as follows. 0 protects nothing. 1 protects addresses whose top two bits are 11 (C0..FF at 8 bits). 2 protects addresses whose top bit is 1 (80..FF). 3 protects every address.
- R5: wr_permit_o is 1 exactly when wp_i is 1, the enable latch is set, the unit is idle, and addr_i lies outside the protected range.
- R6: mem_wr_i in a cycle where wr_permit_o is 1 sets the busy flag at the next edge. A prog_done_i while busy clears both the busy flag and the enable latch at the next edge.
- R7: sr_wr_i while idle, with wp_i at 1 and the latch set, loads the protection bits from sr_data_i[3:2] and sets the busy flag. The new bits are kept through the program cycle and after it.
- R8: While the busy flag is set, status_o reads 8'hFF.
- R9: A rejected memory or status write does not set the busy flag, does not change the enable latch, and does not change the protection bits.
- R10: While busy, en_set_i, en_clr_i, mem_wr_i and sr_wr_i have no effect. A prog_done_i while idle has no effect.
- R11: en_clr_i does not change the protection bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | 1 | Write-enable command strobe |
| en_clr_i | input | 1 | Write-disable command strobe |
| mem_wr_i | input | 1 | Memory write request strobe |
| sr_wr_i | input | 1 | Status write request strobe |
| sr_data_i | input | 8 | Status byte received with a status write |
| addr_i | input | AW (8) | Target byte address |
| wp_i | input | 1 | Write-protect pin, high to allow writes |
| prog_done_i | input | 1 | End-of-program-cycle pulse |
| wr_permit_o | output | 1 | Memory write at addr_i is allowed |
| status_o | output | 8 | Byte returned by a status read |
| bp_o | output | 2 | Current protection level |

## Verification
The hardest state to reach from the ports is an edge address under a chosen protection level. Reaching it takes an enable, a status write carrying the level, a done pulse, and then a second enable. After that, addr_i and wp_i can be varied on their own. The bench performs this sequence for each of the four levels. It then sweeps addresses 7F, 80, BF, C0 and FF with the pin both low and high, and tries real writes on each side of the boundary. Random single-command traffic, including stray done pulses and commands issued while busy, covers what is ignored during a program cycle.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int unsigned RDY_POS = 0;
  localparam int unsigned WEN_POS = 1;
  localparam int unsigned BP_POS  = 2;
  localparam int unsigned BP_W    = 2;

  typedef logic [BP_W-1:0] bp_t;

  typedef enum logic [BP_W-1:0] {
    LVL_NONE = 2'd0,
    LVL_QTR  = 2'd1,
    LVL_HALF = 2'd2,
    LVL_ALL  = 2'd3
  } prot_lvl_e;
endpackage

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (busy_i) begin
      if (done_i) wel_q <= 1'b0;
    end else if (clr_i) begin
      wel_q <= 1'b0;
    end else if (set_i) begin
      wel_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/busy_flag.sv
module busy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/region_decode.sv
module region_decode #(
  parameter int unsigned AW = 8
) (
  input  prot_pkg::bp_t  bp_i,
  input  logic [AW-1:0]  addr_i,
  output logic           hit_o
);
  import prot_pkg::*;

  logic top_half, top_qtr;
  prot_lvl_e lvl;

  generate
    if (AW >= 2) begin : g_wide
      assign top_half = addr_i[AW-1];
      assign top_qtr  = &addr_i[AW-1:AW-2];
    end else begin : g_narrow
      assign top_half = addr_i[0];
      assign top_qtr  = addr_i[0];
    end
  endgenerate

  assign lvl = prot_lvl_e'(bp_i);

  always_comb begin
    unique case (lvl)
      LVL_NONE: hit_o = 1'b0;
      LVL_QTR:  hit_o = top_qtr;
      LVL_HALF: hit_o = top_half;
      LVL_ALL:  hit_o = 1'b1;
      default:  hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/status_pack.sv
module status_pack #(
  parameter int unsigned SW = 8
) (
  input  logic          busy_i,
  input  logic          wel_i,
  input  prot_pkg::bp_t bp_i,
  output logic [SW-1:0] status_o
);
  import prot_pkg::*;

  localparam int unsigned LOW_W = BP_POS + BP_W;

  logic [SW-1:0] idle_byte;

  assign idle_byte[RDY_POS] = 1'b0;
  assign idle_byte[WEN_POS] = wel_i;
  assign idle_byte[BP_POS +: BP_W] = bp_i;

  generate
    for (genvar i = LOW_W; i < SW; i++) begin : g_pad
      assign idle_byte[i] = 1'b0;
    end
  endgenerate

  // busy masks every field to 1; RDY itself is 1 then
  assign status_o = busy_i ? {SW{1'b1}} : idle_byte;
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl #(
  parameter int unsigned AW = 8,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          mem_wr_i,
  input  logic          sr_wr_i,
  input  logic [SW-1:0] sr_data_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wp_i,
  input  logic          prog_done_i,
  output logic          wr_permit_o,
  output logic [SW-1:0] status_o,
  output logic [1:0]    bp_o
);
  import prot_pkg::*;

  logic wel_q, busy_q, hit, gate_ok, sr_ok, mem_ok;
  bp_t  bp_q;

  assign gate_ok     = wp_i & wel_q & ~busy_q;
  assign wr_permit_o = gate_ok & ~hit;
  assign mem_ok      = mem_wr_i & wr_permit_o;
  assign sr_ok       = sr_wr_i & gate_ok;

  wel_latch u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_q),
    .set_i  (en_set_i),
    .clr_i  (en_clr_i),
    .done_i (prog_done_i),
    .wel_o  (wel_q)
  );

  busy_flag u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mem_ok | sr_ok),
    .done_i  (prog_done_i),
    .busy_o  (busy_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bp_q <= '0;
    else if (sr_ok) bp_q <= sr_data_i[BP_POS +: BP_W];
  end

  region_decode #(.AW(AW)) u_region (
    .bp_i   (bp_q),
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  status_pack #(.SW(SW)) u_stat (
    .busy_i   (busy_q),
    .wel_i    (wel_q),
    .bp_i     (bp_q),
    .status_o (status_o)
  );

  assign bp_o = bp_q;
endmodule

// File: rtl/prot_ctrl_chk.sv
module prot_ctrl_chk #(
  parameter int unsigned SW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_set_i,
  input logic          en_clr_i,
  input logic          mem_wr_i,
  input logic          sr_wr_i,
  input logic          wp_i,
  input logic          prog_done_i,
  input logic          wr_permit_o,
  input logic [SW-1:0] status_o,
  input logic [1:0]    bp_o,
  input logic          wel_q,
  input logic          busy_q
);
  a_r2_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i && !busy_q) |=> !wel_q);

  a_r5_permit_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o |-> (wp_i && wel_q && !busy_q));

  a_r6_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && prog_done_i) |=> (!busy_q && !wel_q));

  a_r6_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && wr_permit_o) |=> busy_q);

  a_r8_busy_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (status_o == {SW{1'b1}}));

  a_r7_bp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_i |=> $stable(bp_o));

  a_r9_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && !wr_permit_o && !busy_q && !sr_wr_i && !en_set_i && !en_clr_i)
      |=> (!busy_q && $stable(wel_q)));

  a_r10_busy_wel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !prog_done_i) |=> (busy_q && $stable(wel_q)));
endmodule

bind prot_ctrl prot_ctrl_chk #(.SW(SW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_set_i    (en_set_i),
  .en_clr_i    (en_clr_i),
  .mem_wr_i    (mem_wr_i),
  .sr_wr_i     (sr_wr_i),
  .wp_i        (wp_i),
  .prog_done_i (prog_done_i),
  .wr_permit_o (wr_permit_o),
  .status_o    (status_o),
  .bp_o        (bp_o),
  .wel_q       (wel_q),
  .busy_q      (busy_q)
);

// File: tb/prot_ctrl_tb.sv
module prot_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       en_set_i = 0, en_clr_i = 0, mem_wr_i = 0, sr_wr_i = 0;
  logic       wp_i = 0, prog_done_i = 0;
  logic [7:0] sr_data_i = 0, addr_i = 0;
  logic       wr_permit_o;
  logic [7:0] status_o;
  logic [1:0] bp_o;

  int errs = 0, checks = 0;
  bit m_wel = 0, m_busy = 0;
  logic [1:0] m_bp = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prot_ctrl u_dut (.*);

  function automatic bit exp_hit(input logic [1:0] lvl, input logic [7:0] a);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return a >= 8'hC0;
      2'd2: return a >= 8'h80;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat();
    return m_busy ? 8'hFF : {4'h0, m_bp, m_wel, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive after negedge, check permit, then state after posedge
  task automatic cyc(input bit s, input bit c, input bit mw, input bit sw,
                     input logic [7:0] d, input logic [7:0] a,
                     input bit wp, input bit dn, input string req);
    bit perm;
    @(negedge clk_i);
    en_set_i = s; en_clr_i = c; mem_wr_i = mw; sr_wr_i = sw;
    sr_data_i = d; addr_i = a; wp_i = wp; prog_done_i = dn;
    #1;
    perm = wp && m_wel && !m_busy && !exp_hit(m_bp, a);
    chk({req, "/R5 permit"}, {7'b0, wr_permit_o}, {7'b0, perm});
    @(posedge clk_i);
    if (m_busy) begin
      if (dn) begin m_busy = 0; m_wel = 0; end
    end else begin
      if (sw && wp && m_wel) begin m_bp = d[3:2]; m_busy = 1; end
      else if (mw && perm) m_busy = 1;
      if (c) m_wel = 0;
      else if (s) m_wel = 1;
    end
    #1;
    chk({req, "/R3 status"}, status_o, exp_stat());
    chk({req, "/R11 bp"}, {6'b0, bp_o}, {6'b0, m_bp});
  endtask

  task automatic idle(input logic [7:0] a, input bit wp, input string req);
    cyc(0, 0, 0, 0, 8'h00, a, wp, 0, req);
  endtask

  task automatic set_level(input logic [1:0] lvl);
    cyc(1, 0, 0, 0, 8'h00, 8'h00, 1, 0, "R2 set");
    cyc(0, 0, 0, 1, {4'hA, lvl, 2'b01}, 8'h00, 1, 0, "R7 srwr");
    idle(8'h00, 1, "R8 busy");
    cyc(0, 0, 0, 0, 8'h00, 8'h00, 1, 1, "R7 done");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] edges [5] = '{8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
    void'($urandom(32'h5EED_0042));
    #3;
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset bp", {6'b0, bp_o}, 8'h00);
    chk("R1 reset permit", {7'b0, wr_permit_o}, 8'h00);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(8'h00, 1, "R1 after");

    // R2: simultaneous set and clear
    cyc(1, 1, 0, 0, 0, 0, 1, 0, "R2 both");
    cyc(1, 0, 0, 0, 0, 0, 1, 0, "R2 set");
    cyc(0, 1, 0, 0, 0, 0, 1, 0, "R2 clr");
    // R9: rejected writes with latch clear or pin low
    cyc(0, 0, 1, 0, 0, 8'h10, 1, 0, "R9 mw nowel");
    cyc(1, 0, 0, 0, 0, 0, 1, 0, "R2 set");
    cyc(0, 0, 0, 1, 8'h0C, 0, 0, 0, "R9 sw wp0");
    cyc(0, 0, 1, 0, 0, 8'h10, 0, 0, "R9 mw wp0");
    // R10: commands during busy are ignored
    cyc(0, 0, 1, 0, 0, 8'h10, 1, 0, "R6 start");
    cyc(0, 1, 0, 0, 0, 0, 1, 0, "R10 clr busy");
    cyc(0, 0, 0, 1, 8'h0C, 0, 1, 0, "R10 sw busy");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R6 done");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R10 stray done");

    // R4: sweep levels x edge addresses x pin
    for (int lvl = 0; lvl < 4; lvl++) begin
      set_level(lvl[1:0]);
      cyc(1, 0, 0, 0, 0, 0, 1, 0, "R2 set");
      foreach (edges[i]) begin
        idle(edges[i], 0, "R4 wp0");
        idle(edges[i], 1, "R4 wp1");
      end
      cyc(0, 0, 1, 0, 0, lvl[0] ? 8'hC0 : 8'h80, 1, 0, "R9 edge wr");
      if (m_busy) cyc(0, 0, 0, 0, 0, 0, 1, 1, "R6 done");
      cyc(1, 0, 0, 0, 0, 0, 1, 0, "R2 set");
      cyc(0, 0, 1, 0, 0, 8'h7F, 1, 0, "R6 low wr");
      if (m_busy) cyc(0, 0, 0, 0, 0, 0, 1, 1, "R6 done");
      cyc(0, 1, 0, 0, 0, 0, 1, 0, "R11 clr");
    end

    // random single-command traffic
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 6);
      logic [7:0] a = 8'($urandom);
      logic [7:0] d = 8'($urandom);
      bit wp = ($urandom_range(0, 3) != 0);
      if (m_busy && $urandom_range(0, 2) == 0) op = 5;
      cyc(op == 0, op == 1, op == 2, op == 3, d, a, wp, op == 5, "R10 rand");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule